// File: doc/BRIEF.md
# VRAM Fill Engine

This block writes a repeated byte value across video memory. The host gives a start address, a per-access address step and a byte count. It then arms fill mode and writes one word to the data port. That word is stored like any other data-port write. After it, the engine writes a fill byte once per usable memory slot. After each byte it advances the address by the step, and it stops when the count is exhausted.

The fill byte is the high byte of the word most recently written to the data port. Words written while a fill is running are queued and stored ahead of any further fill bytes. From the next cycle on, the high byte of such a word becomes the fill value for the remaining bytes. A slot marked as refresh performs no access. Every stored word costs two slots, one per byte. Fill bytes cost one slot each.

Top module: `vram_fill_engine`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `mem_we_o` and `fifo_full_o` are all 0.
- R2: An accepted data-port word is stored in two usable slots, in this order: high byte at the current address with bit 0 forced to 0, then low byte at the same address with bit 0 forced to 1. After the low byte, the address advances by `fill_incr_i` modulo 2^AW. `addr_load_i` loads `addr_i` as the current address.
- R3: A data-port write accepted while `fill_mode_i` is 1 and no fill is running starts a fill. That trigger word is stored as in R2 and is not counted in the fill length.
- R4: Each fill access writes the fill byte at the exact current address and then adds `fill_incr_i` modulo 2^AW. Exactly the programmed number of fill bytes are written.
- R5: A `fill_len_i` of 0 writes 65536 fill bytes.
- R6: The fill byte is the high byte of the last accepted data-port word. A word written during a fill is stored per R2, and its high byte is used for the fill bytes that follow, starting from the cycle after the write.
- R7: In a cycle with `refresh_i` high, or with `slot_i` low, no memory write occurs and the pending work is kept for later.
- R8: `busy_o` rises in the cycle after the trigger write. It falls in the cycle after the last fill byte is written.
- R9: While data-port words are queued, no fill byte is written. Queued words always go first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_mode_i | input | 1 | Next data-port write starts a fill |
| fill_len_i | input | LW | Fill byte count, 0 means 2^LW |
| fill_incr_i | input | IW | Address step per access |
| addr_load_i | input | 1 | Load current address |
| addr_i | input | AW | Address to load |
| dwr_valid_i | input | 1 | Data-port write strobe |
| dwr_data_i | input | 16 | Data-port word |
| slot_i | input | 1 | Memory access slot available this cycle |
| refresh_i | input | 1 | This slot is taken by refresh |
| fifo_full_o | output | 1 | Write queue full, writes are dropped |
| mem_we_o | output | 1 | Byte write strobe |
| mem_addr_o | output | AW | Byte write address |
| mem_data_o | output | 8 | Byte write data |
| busy_o | output | 1 | Fill in progress |

## Verification
A data-port write can land in the same cycle as a fill byte access. The pushed word must not pre-empt the access already granted in that cycle, and its high byte must not yet be used. The bench provokes this by writing a word several cycles into a running fill while a slot is free on every cycle. A behavioural model holding a word queue, a remaining count and the fill byte predicts the address and data of every access. The byte pattern left in memory is also checked against hand-computed values.

// File: rtl/vram_fill_pkg.sv
package vram_fill_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/vram_fill_fifo.sv
module vram_fill_fifo
  import vram_fill_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] store_q [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = store_q[rd_ptr_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) store_q[wr_ptr_q] <= push_data_i;
  end

  assert_pop_nonempty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/vram_fill_ctrl.sv
module vram_fill_ctrl
  import vram_fill_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned IW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              usable_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] push_data_i,
  input  logic              fill_mode_i,
  input  logic [LW-1:0]     fill_len_i,
  input  logic [IW-1:0]     fill_incr_i,
  input  logic              addr_load_i,
  input  logic [AW-1:0]     addr_i,
  output logic              pop_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_data_o,
  output logic              busy_o
);
  localparam int unsigned RW = LW + 1;

  logic [AW-1:0]     addr_q;
  logic              phase_q;   // 0: high byte next, 1: low byte next
  logic              active_q;
  logic [RW-1:0]     rem_q;
  logic [BYTE_W-1:0] fill_byte_q;
  logic              word_wr, fill_wr, advance, trigger;

  assign word_wr = usable_i & ~fifo_empty_i;
  assign fill_wr = usable_i & fifo_empty_i & active_q;
  assign pop_o   = word_wr & phase_q;
  assign advance = pop_o | fill_wr;
  assign trigger = push_i & fill_mode_i & ~active_q;
  assign busy_o  = active_q;

  always_comb begin
    mem_we_o   = word_wr | fill_wr;
    mem_addr_o = addr_q;
    mem_data_o = fill_byte_q;
    if (word_wr) begin
      mem_addr_o = {addr_q[AW-1:1], phase_q};
      mem_data_o = phase_q ? head_i[BYTE_W-1:0] : head_i[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      phase_q     <= 1'b0;
      active_q    <= 1'b0;
      rem_q       <= '0;
      fill_byte_q <= '0;
    end else begin
      if (addr_load_i)  addr_q <= addr_i;
      else if (advance) addr_q <= addr_q + AW'(fill_incr_i);
      if (word_wr) phase_q <= ~phase_q;
      if (push_i)  fill_byte_q <= push_data_i[WORD_W-1:BYTE_W];
      if (trigger) begin
        active_q <= 1'b1;
        rem_q    <= (fill_len_i == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, fill_len_i};
      end else if (fill_wr) begin
        rem_q <= rem_q - RW'(1);
        if (rem_q == RW'(1)) active_q <= 1'b0;
      end
    end
  end

  assert_rem_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !fill_wr && !trigger) |=> $stable(rem_q));
  assert_zero_len_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger && fill_len_i == '0) |=> rem_q[LW]);
  assert_fill_byte_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> fill_byte_q == $past(push_data_i[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/vram_fill_engine.sv
module vram_fill_engine
  import vram_fill_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned LW    = 16,
  parameter int unsigned IW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_mode_i,
  input  logic [LW-1:0]     fill_len_i,
  input  logic [IW-1:0]     fill_incr_i,
  input  logic              addr_load_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              dwr_valid_i,
  input  logic [15:0]       dwr_data_i,
  input  logic              slot_i,
  input  logic              refresh_i,
  output logic              fifo_full_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              busy_o
);
  logic              usable, push, pop, fifo_empty;
  logic [WORD_W-1:0] head;

  assign usable = slot_i & ~refresh_i;
  assign push   = dwr_valid_i & ~fifo_full_o;

  vram_fill_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (dwr_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full_o)
  );

  vram_fill_ctrl #(.AW(AW), .LW(LW), .IW(IW)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .usable_i     (usable),
    .fifo_empty_i (fifo_empty),
    .head_i       (head),
    .push_i       (push),
    .push_data_i  (dwr_data_i),
    .fill_mode_i  (fill_mode_i),
    .fill_len_i   (fill_len_i),
    .fill_incr_i  (fill_incr_i),
    .addr_load_i  (addr_load_i),
    .addr_i       (addr_i),
    .pop_o        (pop),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .busy_o       (busy_o)
  );

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr_valid_i |-> !fifo_full_o);
  assert_refresh_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |-> !mem_we_o);
  assert_busy_ends_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_we_o));
  assert_words_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fifo_empty && usable) |=> busy_o);
endmodule

// File: tb/test_vram_fill_engine.sv
module test_vram_fill_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fill_mode_i = 1'b0;
  logic [15:0] fill_len_i = '0;
  logic [7:0]  fill_incr_i = '0;
  logic        addr_load_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        dwr_valid_i = 1'b0;
  logic [15:0] dwr_data_i = '0;
  logic        slot_i = 1'b0;
  logic        refresh_i = 1'b0;
  logic        fifo_full_o, mem_we_o, busy_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  vram_fill_engine i_vram_fill_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_mode_i(fill_mode_i), .fill_len_i(fill_len_i),
    .fill_incr_i(fill_incr_i), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .dwr_valid_i(dwr_valid_i), .dwr_data_i(dwr_data_i), .slot_i(slot_i),
    .refresh_i(refresh_i), .fifo_full_o(fifo_full_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .busy_o(busy_o)
  );

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;
  int smode = 0, cyc = 0;
  int nwr = 0;
  bit [7:0] dmem [int];

  // reference model state
  int m_addr = 0, m_phase = 0, m_rem = 0, m_fb = 0, kind = 0;
  bit m_active = 0;
  int q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    case (smode)
      1: begin slot_i <= 1'b1; refresh_i <= (cyc % 5 == 0); end
      2: begin slot_i <= cyc[0]; refresh_i <= 1'b0; end
      default: begin slot_i <= rst_ni; refresh_i <= 1'b0; end
    endcase
  end

  always @(negedge clk_i) begin
    int e_we, e_addr, e_data;
    #1;
    e_we = 0; e_addr = 0; e_data = 0; kind = 0;
    if (rst_ni && slot_i && !refresh_i) begin
      if (q.size() > 0) begin
        e_we = 1; kind = 1;
        e_addr = m_phase ? (m_addr | 1) : (m_addr & 'hFFFE);
        e_data = m_phase ? (q[0] & 'hFF) : ((q[0] >> 8) & 'hFF);
      end else if (m_active) begin
        e_we = 1; kind = 2; e_addr = m_addr; e_data = m_fb;
      end
    end
    if (rst_ni) begin
      check(mem_we_o === e_we[0] && busy_o === m_active &&
            (!e_we || (mem_addr_o === e_addr[15:0] && mem_data_o === e_data[7:0])),
            "R2 R4 R6 R7 R8 R9 cycle model",
            {8'(mem_we_o), 8'(busy_o), mem_addr_o}, {8'(e_we), 8'(m_active), e_addr[15:0]});
      if (refresh_i) check(!mem_we_o, "R7 refresh write", mem_we_o, 0);
      if (mem_we_o) begin dmem[int'(mem_addr_o)] = mem_data_o; nwr++; end
    end
  end

  always @(posedge clk_i) begin
    bit pre_act;
    int pre_size;
    if (!rst_ni) begin
      m_addr = 0; m_phase = 0; m_rem = 0; m_fb = 0; m_active = 0; q.delete();
    end else begin
      pre_act = m_active; pre_size = q.size();
      if (kind == 1) begin
        if (m_phase == 1) begin
          void'(q.pop_front()); m_phase = 0; m_addr = (m_addr + int'(fill_incr_i)) & 'hFFFF;
        end else m_phase = 1;
      end else if (kind == 2) begin
        m_addr = (m_addr + int'(fill_incr_i)) & 'hFFFF;
        m_rem--;
        if (m_rem == 0) m_active = 0;
      end
      if (dwr_valid_i && pre_size < 4) begin
        q.push_back(int'(dwr_data_i));
        m_fb = int'(dwr_data_i[15:8]);
        if (fill_mode_i && !pre_act) begin
          m_active = 1;
          m_rem = (fill_len_i == 0) ? 65536 : int'(fill_len_i);
        end
      end
      if (addr_load_i) m_addr = int'(addr_i);
    end
  end

  task automatic wr_word(input logic [15:0] d);
    @(negedge clk_i); dwr_valid_i = 1'b1; dwr_data_i = d;
    @(negedge clk_i); dwr_valid_i = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    @(negedge clk_i); addr_load_i = 1'b1; addr_i = a;
    @(negedge clk_i); addr_load_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (busy_o || m_active || q.size() > 0);
    @(negedge clk_i);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    #1;
    check(!busy_o && !mem_we_o && !fifo_full_o, "R1 reset outputs",
          {busy_o, mem_we_o, fifo_full_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 plain word write
    fill_incr_i = 8'd2;
    set_addr(16'h0041);
    wr_word(16'h1234);
    wait_idle();
    check(dmem[32'h40] == 8'h12, "R2 high byte even", dmem[32'h40], 8'h12);
    check(dmem[32'h41] == 8'h34, "R2 low byte odd", dmem[32'h41], 8'h34);

    // R3 R4 fill of three bytes, step 2
    set_addr(16'h0100);
    fill_len_i = 16'd3; fill_mode_i = 1'b1;
    nwr = 0;
    wr_word(16'hAB12);
    fill_mode_i = 1'b0;
    #2;
    check(busy_o === 1'b1, "R8 busy after trigger", busy_o, 1);
    wait_idle();
    check(nwr == 5, "R3 trigger not counted", nwr, 5);
    check(dmem[32'h101] == 8'h12, "R3 trigger stored", dmem[32'h101], 8'h12);
    check(dmem[32'h102] == 8'hAB && dmem[32'h104] == 8'hAB && dmem[32'h106] == 8'hAB,
          "R4 fill bytes", dmem[32'h106], 8'hAB);
    check(!dmem.exists(32'h108), "R4 length exact", 1, 0);

    // R4 address wrap
    fill_incr_i = 8'd4;
    set_addr(16'hFFFE);
    fill_len_i = 16'd2; fill_mode_i = 1'b1;
    wr_word(16'hC35A);
    fill_mode_i = 1'b0;
    wait_idle();
    check(dmem[32'hFFFF] == 8'h5A, "R2 word at top", dmem[32'hFFFF], 8'h5A);
    check(dmem[32'h2] == 8'hC3 && dmem[32'h6] == 8'hC3, "R4 wrap modulo", dmem[32'h6], 8'hC3);
    check(!dmem.exists(32'hA), "R4 wrap length", 1, 0);

    // R7 refresh and sparse slots
    smode = 1;
    fill_incr_i = 8'd1;
    set_addr(16'h0300);
    fill_len_i = 16'd10; fill_mode_i = 1'b1;
    wr_word(16'h9900);
    fill_mode_i = 1'b0;
    wait_idle();
    check(dmem[32'h30A] == 8'h99, "R7 last fill after refresh", dmem[32'h30A], 8'h99);
    check(!dmem.exists(32'h30B), "R7 no extra write", 1, 0);
    smode = 2;
    set_addr(16'h0400);
    fill_len_i = 16'd4; fill_mode_i = 1'b1;
    wr_word(16'h6611);
    fill_mode_i = 1'b0;
    wait_idle();
    check(dmem[32'h404] == 8'h66 && !dmem.exists(32'h405), "R7 sparse slots", dmem[32'h404], 8'h66);
    smode = 0;

    // R6 R9 write during fill, same cycle as a fill access
    fill_incr_i = 8'd2;
    set_addr(16'h0200);
    fill_len_i = 16'd20; fill_mode_i = 1'b1;
    wr_word(16'h5500);
    fill_mode_i = 1'b0;
    repeat (6) @(negedge clk_i);
    wr_word(16'h77EE);
    wait_idle();
    check(dmem[32'h202] == 8'h55, "R6 first fill value", dmem[32'h202], 8'h55);
    check(dmem[32'h22A] == 8'h77, "R6 new fill value", dmem[32'h22A], 8'h77);
    check(!dmem.exists(32'h22C), "R9 word does not shorten fill", 1, 0);
    n = 0;
    for (int a = 32'h203; a <= 32'h22B; a += 2) if (dmem.exists(a) && dmem[a] == 8'hEE) n++;
    check(n == 1, "R9 mid-fill word stored", n, 1);

    // R5 zero length
    fill_incr_i = 8'd1;
    set_addr(16'h0000);
    fill_len_i = 16'd0; fill_mode_i = 1'b1;
    nwr = 0;
    wr_word(16'h4200);
    fill_mode_i = 1'b0;
    wait_idle();
    check(nwr == 65538, "R5 zero length count", nwr, 65538);
    check(dmem[32'hFFFF] == 8'h42 && dmem[32'h0] == 8'h42, "R5 full span", dmem[32'h0], 8'h42);
    check(!busy_o, "R8 idle at end", busy_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule